// File: doc/BRIEF.md
# SD Card SPI Host Port

This block is a byte-oriented SPI master that sits on an 8-bit microprocessor peripheral bus. Host software reaches it through a window of four registers: a data port, a status port, a clock-control port and a chip-select port. A write to the data port starts one eight-bit full-duplex exchange with the card. The byte the card returned can be read back from the same port once the exchange is over. To fetch a byte from the card, software writes a filler byte such as 0xFF and then reads the port.

The serial clock comes from one of two tick inputs. Each tick marks one period of an external source clock: a slow bus-phase clock or a fast 7 MHz-class clock. A divider set from 2 to 8 sits between the selected source and the serial clock. Software can poll a completion flag instead of counting delays. The same status port carries the synchronised card-present and write-protect levels. An activity output lights whenever the card is selected or an exchange is running.

Top module: `sdspi_bus_master`

## Requirements
- R1: After reset, status and control read 0x00, chip-select reads 0, spi_cs_n is 1, spi_sck is 0, spi_mosi is 1 and led is 0.
- R2: A bus write to offset 0 while no exchange runs starts one. From the next cycle, status bit 6 (busy) reads 1 and status bit 7 (complete) reads 0.
- R3: Bits move MSB first in SPI mode 0. The card captures on each rising spi_sck the byte that was written to offset 0. The byte sampled on spi_miso at the rising edges reads back from offset 0 after the exchange.
- R4: When the eighth bit has been sampled and spi_sck falls, busy clears and complete sets in the same cycle. Complete then stays 1 until the next data write that is accepted.
- R5: Control bits 2:0 hold a code, and the divisor is that code plus 2. A written code of 7 is stored as 6. The spi_sck period is the divisor times the selected tick period.
- R6: Control bit 3 selects the tick source: 0 selects slow_tick and 1 selects fast_tick.
- R7: A write to offset 0 during an exchange is ignored. The byte sent and the byte received are those of the exchange already running.
- R8: Offset 3 bit 0 reads back as written. Writing 1 drives spi_cs_n to 0, and writing 0 drives it back to 1.
- R9: Status bit 5 shows card_present and bit 4 shows write_prot, each through a two-stage synchroniser.
- R10: led is 1 exactly when chip-select is active or an exchange is busy.
- R11: While no exchange runs, spi_sck is 0 and spi_mosi is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register window selected this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from offset) |
| slow_tick | input | 1 | One-cycle pulse per slow source period |
| fast_tick | input | 1 | One-cycle pulse per fast source period |
| card_present | input | 1 | Card-detect level, asynchronous |
| write_prot | input | 1 | Write-protect level, asynchronous |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to card |
| spi_miso | input | 1 | Serial data from card |
| spi_cs_n | output | 1 | Active-low card select |
| led | output | 1 | Activity indicator |

## Verification
Register writes take effect at the clock edge that captures them. The bench therefore reads busy, complete, control and chip-select at the falling edge that follows that capture edge. Sense inputs pass through two flops, so the bench waits three edges before it reads them. Exchange length depends on the tick rate, so the bench polls the complete flag with a timeout instead of waiting a fixed cycle count. It measures the spi_sck period from the timestamps of the last two rising edges and compares it with the divisor times the tick period. The serial byte is checked in a card model that captures on rising spi_sck and shifts on falling spi_sck.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 2;
    localparam int CODE_W = 3;
    localparam int DIV_W  = CODE_W + 1;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 2'd0,
        OFS_STAT = 2'd1,
        OFS_CTRL = 2'd2,
        OFS_CSEL = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic              fast;
        logic [CODE_W-1:0] code;
    } clk_ctrl_t;

    typedef struct packed {
        logic       done;
        logic       busy;
        logic       present;
        logic       protect;
        logic [3:0] zero;
    } status_t;

    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
        return (c == 3'd7) ? 3'd6 : c;
    endfunction

endpackage

// File: rtl/sdspi_sync.sv
module sdspi_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= (s == 0) ? d_async : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sdspi_sck_gen.sv
module sdspi_sck_gen
    import sdspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  clk_ctrl_t         ctrl,
    output logic              sck,
    output logic              rise_stb,
    output logic              fall_stb
);
    logic [DIV_W-1:0] divisor, hi_len, lo_len, cnt;
    logic             tick, sck_q;

    assign divisor  = {1'b0, ctrl.code} + DIV_W'(2);
    assign hi_len   = divisor >> 1;
    assign lo_len   = divisor - hi_len;
    assign tick     = ctrl.fast ? fast_tick : slow_tick;
    assign rise_stb = run && tick && !sck_q && (cnt == lo_len - DIV_W'(1));
    assign fall_stb = run && tick &&  sck_q && (cnt == hi_len - DIV_W'(1));
    assign sck      = sck_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sck_q <= 1'b0;
            cnt   <= '0;
        end else if (tick) begin
            if (rise_stb || fall_stb) begin
                sck_q <= ~sck_q;
                cnt   <= '0;
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdspi_shifter.sv
module sdspi_shifter
    import sdspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              miso,
    output logic              busy,
    output logic              finish,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int BC_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shreg;
    logic [BC_W-1:0]   bit_idx;
    logic              miso_q;

    assign finish = busy && fall_stb && (bit_idx == BC_W'(BYTE_W-1));
    assign mosi   = busy ? shreg[BYTE_W-1] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_idx <= '0;
            busy    <= 1'b0;
            miso_q  <= 1'b0;
            rx_byte <= '0;
        end else if (start && !busy) begin
            shreg   <= tx_byte;
            bit_idx <= '0;
            busy    <= 1'b1;
        end else if (busy) begin
            if (rise_stb) miso_q <= miso;
            if (fall_stb) begin
                shreg <= {shreg[BYTE_W-2:0], miso_q};
                if (finish) begin
                    busy    <= 1'b0;
                    rx_byte <= {shreg[BYTE_W-2:0], miso_q};
                end else begin
                    bit_idx <= bit_idx + BC_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sdspi_bus_master.sv
module sdspi_bus_master
    import sdspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              card_present,
    input  logic              write_prot,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    output logic              led
);
    clk_ctrl_t         ctrl_q;
    logic              cs_q, tc_q, eng_busy, eng_finish;
    logic              rise_stb, fall_stb, wr_data;
    logic [1:0]        sense;
    logic [BYTE_W-1:0] rx_byte;
    logic [CODE_W-1:0] div_code;
    status_t           stat;

    assign wr_data  = bus_sel && bus_we && (bus_addr == OFS_DATA);
    assign div_code = ctrl_q.code;

    sdspi_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .d_async({card_present, write_prot}), .q_sync(sense)
    );

    sdspi_sck_gen u_sck (
        .clk(clk), .rst(rst), .run(eng_busy),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .ctrl(ctrl_q),
        .sck(spi_sck), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    sdspi_shifter u_shift (
        .clk(clk), .rst(rst), .start(wr_data), .tx_byte(bus_wdata),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .miso(spi_miso),
        .busy(eng_busy), .finish(eng_finish), .mosi(spi_mosi), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cs_q   <= 1'b0;
            tc_q   <= 1'b0;
        end else begin
            if (bus_sel && bus_we && bus_addr == OFS_CTRL) begin
                ctrl_q.fast <= bus_wdata[3];
                ctrl_q.code <= clamp_code(bus_wdata[2:0]);
            end
            if (bus_sel && bus_we && bus_addr == OFS_CSEL)
                cs_q <= bus_wdata[0];
            if (wr_data && !eng_busy) tc_q <= 1'b0;
            else if (eng_finish)      tc_q <= 1'b1;
        end
    end

    always_comb begin
        stat         = '0;
        stat.done    = tc_q;
        stat.busy    = eng_busy;
        stat.present = sense[1];
        stat.protect = sense[0];
        case (bus_addr)
            OFS_DATA: bus_rdata = rx_byte;
            OFS_STAT: bus_rdata = stat;
            OFS_CTRL: bus_rdata = {4'b0, ctrl_q};
            default:  bus_rdata = {7'b0, cs_q};
        endcase
    end

    assign spi_cs_n = ~cs_q;
    assign led      = cs_q | eng_busy;
endmodule

// File: rtl/sdspi_bus_master_chk.sv
module sdspi_bus_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       busy,
    input logic       tc,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic       spi_cs_n,
    input logic       led,
    input logic [2:0] div_code
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == 2'd0 && !busy) |=> (busy && !tc));
    // R4
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> tc);
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tc && !(bus_sel && bus_we && bus_addr == 2'd0)) |=> tc);
    // R11
    idle_sck_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sck);
    // R11
    idle_mosi_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_mosi);
    // R10
    led_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> led);
    // R8
    csel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == 2'd3) |=> (spi_cs_n == !$past(bus_wdata[0])));
    // R5
    code_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        div_code != 3'd7);
endmodule

bind sdspi_bus_master sdspi_bus_master_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(eng_busy), .tc(tc_q),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .led(led),
    .div_code(div_code)
);

// File: tb/sdspi_bus_master_bench.sv
module sdspi_bus_master_bench;
    localparam int CLK_PER  = 10;
    localparam int SLOW_PER = 6;
    localparam int FAST_PER = 2;

    logic       clk = 1'b0, rst = 1'b1;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       slow_tick = 1'b0, fast_tick = 1'b0;
    logic       card_present = 1'b0, write_prot = 1'b0;
    logic       spi_sck, spi_mosi, spi_miso, spi_cs_n, led;

    int n_chk = 0, n_bad = 0;

    // card model
    logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
    int         slv_cnt = 0, slv_base = 0, slv_k;
    time        t_last = 0, t_prev = 0;

    always @(negedge spi_sck) slv_cnt <= slv_cnt + 1;
    always @(posedge spi_sck) begin
        slv_rx <= {slv_rx[6:0], spi_mosi};
        t_prev = t_last;
        t_last = $time;
    end
    assign slv_k    = slv_cnt - slv_base;
    assign spi_miso = (slv_k >= 0 && slv_k < 8) ? slv_tx[3'(7 - slv_k)] : 1'b1;

    sdspi_bus_master u_sdspi_bus_master (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slow_tick(slow_tick), .fast_tick(fast_tick),
        .card_present(card_present), .write_prot(write_prot),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .led(led)
    );

    always #(CLK_PER/2) clk = ~clk;

    initial begin
        int sc = 0, fc = 0;
        forever begin
            @(negedge clk);
            slow_tick = (sc == SLOW_PER-1);
            fast_tick = (fc == FAST_PER-1);
            sc = (sc == SLOW_PER-1) ? 0 : sc + 1;
            fc = (fc == FAST_PER-1) ? 0 : fc + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_done(output logic ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, s);
            if (s[7]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        rd(2'd2, v); chk("R1 control", v, 8'h00);
        rd(2'd3, v); chk("R1 chip-select", v, 8'h00);
        chk("R1 cs_n", spi_cs_n, 1'b1);
        chk("R1 sck", spi_sck, 1'b0);
        chk("R1 mosi", spi_mosi, 1'b1);
        chk("R1 led", led, 1'b0);
    endtask

    task automatic t_xfer(input logic [7:0] tx, input logic [7:0] card, input logic [7:0] ctl,
                          input logic [7:0] ctl_rb);
        logic [7:0] v;
        logic ok;
        int per, div;
        wr(2'd2, ctl);
        rd(2'd2, v); chk("R5 control readback", v, ctl_rb);
        slv_tx = card; slv_base = slv_cnt;
        wr(2'd0, tx);
        rd(2'd1, v);
        chk("R2 busy after write", v[6], 1'b1);
        chk("R2 complete cleared", v[7], 1'b0);
        chk("R10 led while busy", led, 1'b1);
        wait_done(ok);
        chk("R4 exchange finished", ok, 1'b1);
        rd(2'd1, v); chk("R4 busy clear", v[6], 1'b0);
        chk("R3 card received", slv_rx, tx);
        rd(2'd0, v); chk("R3 data readback", v, card);
        chk("R11 idle sck", spi_sck, 1'b0);
        chk("R11 idle mosi", spi_mosi, 1'b1);
        div = int'(ctl_rb[2:0]) + 2;
        per = int'((t_last - t_prev) / CLK_PER);
        chk(ctl_rb[3] ? "R6 fast source period R5" : "R6 slow source period R5",
            per, div * (ctl_rb[3] ? FAST_PER : SLOW_PER));
    endtask

    task automatic t_hold;
        logic [7:0] v;
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R4 complete holds", v[7], 1'b1);
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        logic ok;
        wr(2'd2, 8'h08);
        slv_tx = 8'h6E; slv_base = slv_cnt;
        wr(2'd0, 8'h81);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h7F);
        wait_done(ok);
        chk("R7 finished", ok, 1'b1);
        chk("R7 byte sent unchanged", slv_rx, 8'h81);
        rd(2'd0, v); chk("R7 byte received", v, 8'h6E);
    endtask

    task automatic t_csel;
        logic [7:0] v;
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R8 readback", v, 8'h01);
        chk("R8 cs_n low", spi_cs_n, 1'b0);
        chk("R10 led with cs", led, 1'b1);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R8 readback off", v, 8'h00);
        chk("R8 cs_n high", spi_cs_n, 1'b1);
        chk("R10 led off", led, 1'b0);
    endtask

    task automatic t_sense;
        logic [7:0] v;
        @(negedge clk); card_present = 1'b1; write_prot = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R9 present only", v[5:4], 2'b10);
        @(negedge clk); card_present = 1'b0; write_prot = 1'b1;
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R9 protect only", v[5:4], 2'b01);
        @(negedge clk); card_present = 1'b1;
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R9 both", v[5:4], 2'b11);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PER * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_xfer(8'hA5, 8'h3C, 8'h00, 8'h00);
        t_hold();
        t_xfer(8'h5A, 8'hC3, 8'h08, 8'h08);
        t_xfer(8'h01, 8'h80, 8'h0F, 8'h0E);
        t_xfer(8'hF0, 8'h0F, 8'h09, 8'h09);
        t_xfer(8'hFF, 8'h96, 8'h04, 8'h04);
        t_ignore();
        t_csel();
        t_sense();
        summary();
        $finish;
    end
endmodule